// File: doc/BRIEF.md
# DMA Channel Event Trigger Controller

This block decides, for a single DMA channel, when a transfer is launched and when it is cut short. Software programs a 32-bit control word through a plain write port and reads it back combinationally. The word selects one interrupt number that launches a transfer and another that terminates one, each with its own enable. It also arms an optional abort on a pattern-match indication from an external comparator. Two write-one command bits let software force a start or an abort directly.

Interrupts arrive as a stream of 8-bit numbers qualified by a valid strobe. The block accepts one number in every cycle and never applies back-pressure, so the stream has no ready signal. Each accepted number is compared against both programmed values in the same cycle. The block emits registered single-cycle start and abort pulses one clock after their cause. It emits a one-cycle enable-clear pulse when a pattern match ends the transfer. It keeps a sticky abort flag that holds until a separate clear input removes it.

Top module: `dma_evt_trigger`

## Requirements
- R1: After reset the control word reads 0x00FFFF00: both interrupt-number fields are all ones, the enable bits are 0, and all pulse outputs and the abort flag are low.
- R2: A write stores the abort number in bits 23:16, the start number in bits 15:8, the pattern-abort enable in bit 5, the start-IRQ enable in bit 4 and the abort-IRQ enable in bit 3. It takes effect from the next cycle. Bits 31:24, 7, 6 and 2:0 always read 0.
- R3: With bit 4 set, a valid interrupt whose number equals the start field raises `start_pulse` for one cycle, in the cycle after the interrupt. A different number, or any number while bit 4 is clear, gives no pulse.
- R4: With bit 3 set, a valid interrupt whose number equals the abort field raises `abort_pulse` for one cycle, in the cycle after the interrupt, and sets the abort flag. While bit 3 is clear, that interrupt has no effect.
- R5: A write with bit 7 set raises `start_pulse` in the next cycle.
- R6: A write with bit 6 set raises `abort_pulse` in the next cycle.
- R7: With bit 5 set, `pat_match` high raises `abort_pulse` and `chan_en_clr` in the next cycle. With bit 5 clear, `pat_match` has no effect.
- R8: When any abort cause and any start cause occur in the same cycle, only `abort_pulse` is raised. This includes the case where both fields hold the same number.
- R9: A start cause raises `start_pulse` only if `chan_en` is high in the cycle of the cause.
- R10: The abort flag is set by every abort cause and stays high until `abort_flag_clr` is applied. A new abort in the same cycle as the clear leaves the flag set.
- R11: `chan_en_clr` is raised only for a pattern-match abort, never for an interrupt or software abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| irq_valid | input | 1 | Interrupt stream valid strobe |
| irq_num | input | 8 | Interrupt number |
| chan_en | input | 1 | Channel enable state |
| pat_match | input | 1 | Pattern comparator hit |
| abort_flag_clr | input | 1 | Clears the sticky abort flag |
| start_pulse | output | 1 | One-cycle transfer start |
| abort_pulse | output | 1 | One-cycle transfer abort |
| chan_en_clr | output | 1 | One-cycle request to clear the channel enable |
| abort_flag | output | 1 | Sticky abort indication |

## Verification
The start path is driven with a matching number, a neighbouring number, a matching number with its enable clear, and a matching number while the channel is disabled. These patterns separate the comparator from the enable gate and from the channel gate. The abort path is driven by an interrupt, by software and by a pattern hit, both with pattern abort armed and disarmed. This shows which sources raise the enable-clear pulse. Collision patterns cover a start interrupt with a pattern hit, force and abort written together, and equal start and abort fields. They confirm that abort wins. A flag clear arriving together with a fresh abort shows that a set outranks a clear.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int CFG_W      = 32;
  localparam int BIT_FORCE  = 7;
  localparam int BIT_KILL   = 6;
  localparam int BIT_PATEN  = 5;
  localparam int BIT_STEN   = 4;
  localparam int BIT_ABEN   = 3;
  localparam int START_LSB  = 8;

  typedef struct packed {
    logic irq_start;
    logic sw_start;
    logic irq_abort;
    logic sw_abort;
    logic pat_abort;
  } evt_cause_t;
endpackage

// File: rtl/dma_evt_regs.sv
module dma_evt_regs
  import dma_evt_pkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [IRQ_W-1:0] start_sel,
  output logic [IRQ_W-1:0] abort_sel,
  output logic             pat_en,
  output logic             st_en,
  output logic             ab_en,
  output logic             sw_start,
  output logic             sw_abort,
  output logic [CFG_W-1:0] rdata
);
  localparam int ABORT_LSB = START_LSB + IRQ_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_sel <= '1;
      abort_sel <= '1;
      pat_en    <= 1'b0;
      st_en     <= 1'b0;
      ab_en     <= 1'b0;
    end else if (we) begin
      start_sel <= wdata[START_LSB +: IRQ_W];
      abort_sel <= wdata[ABORT_LSB +: IRQ_W];
      pat_en    <= wdata[BIT_PATEN];
      st_en     <= wdata[BIT_STEN];
      ab_en     <= wdata[BIT_ABEN];
    end
  end

  // command bits act in the cycle of the write and are never stored
  assign sw_start = we & wdata[BIT_FORCE];
  assign sw_abort = we & wdata[BIT_KILL];

  always_comb begin
    rdata = '0;
    rdata[START_LSB +: IRQ_W] = start_sel;
    rdata[ABORT_LSB +: IRQ_W] = abort_sel;
    rdata[BIT_PATEN]          = pat_en;
    rdata[BIT_STEN]           = st_en;
    rdata[BIT_ABEN]           = ab_en;
  end
endmodule

// File: rtl/dma_evt_match.sv
module dma_evt_match #(
  parameter int IRQ_W = 8
) (
  input  logic             valid,
  input  logic [IRQ_W-1:0] num,
  input  logic [IRQ_W-1:0] sel,
  input  logic             en,
  output logic             hit
);
  assign hit = valid & en & (num == sel);
endmodule

// File: rtl/dma_evt_arb.sv
module dma_evt_arb
  import dma_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  evt_cause_t cause,
  input  logic       chan_en,
  input  logic       flag_clr,
  output logic       start_q,
  output logic       abort_q,
  output logic       en_clr_q,
  output logic       flag_q
);
  logic any_abort, any_start;

  assign any_abort = cause.irq_abort | cause.sw_abort | cause.pat_abort;
  assign any_start = (cause.irq_start | cause.sw_start) & chan_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      abort_q  <= 1'b0;
      en_clr_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      start_q  <= any_start & ~any_abort;
      abort_q  <= any_abort;
      en_clr_q <= cause.pat_abort;
      flag_q   <= any_abort | (flag_q & ~flag_clr);
    end
  end
endmodule

// File: rtl/dma_evt_trigger.sv
module dma_evt_trigger
  import dma_evt_pkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             irq_valid,
  input  logic [IRQ_W-1:0] irq_num,
  input  logic             chan_en,
  input  logic             pat_match,
  input  logic             abort_flag_clr,
  output logic             start_pulse,
  output logic             abort_pulse,
  output logic             chan_en_clr,
  output logic             abort_flag
);
  localparam int N_MATCH = 2;

  logic [IRQ_W-1:0] start_sel, abort_sel;
  logic             pat_en, st_en, ab_en, sw_start, sw_abort;
  logic [IRQ_W-1:0] sel_v [N_MATCH];
  logic             en_v  [N_MATCH];
  logic [N_MATCH-1:0] hit_v;
  evt_cause_t       cause;

  dma_evt_regs #(.IRQ_W(IRQ_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .start_sel(start_sel), .abort_sel(abort_sel), .pat_en(pat_en),
    .st_en(st_en), .ab_en(ab_en), .sw_start(sw_start),
    .sw_abort(sw_abort), .rdata(cfg_rdata)
  );

  // index 0: start comparator, index 1: abort comparator
  assign sel_v[0] = start_sel;
  assign en_v[0]  = st_en;
  assign sel_v[1] = abort_sel;
  assign en_v[1]  = ab_en;

  for (genvar g = 0; g < N_MATCH; g++) begin : g_match
    dma_evt_match #(.IRQ_W(IRQ_W)) u_match (
      .valid(irq_valid), .num(irq_num), .sel(sel_v[g]),
      .en(en_v[g]), .hit(hit_v[g])
    );
  end

  assign cause.irq_start = hit_v[0];
  assign cause.sw_start  = sw_start;
  assign cause.irq_abort = hit_v[1];
  assign cause.sw_abort  = sw_abort;
  assign cause.pat_abort = pat_en & pat_match;

  dma_evt_arb u_arb (
    .clk(clk), .rst_n(rst_n), .cause(cause), .chan_en(chan_en),
    .flag_clr(abort_flag_clr), .start_q(start_pulse), .abort_q(abort_pulse),
    .en_clr_q(chan_en_clr), .flag_q(abort_flag)
  );
endmodule

// File: rtl/dma_evt_trigger_chk.sv
module dma_evt_trigger_chk #(
  parameter int IRQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [31:0]      cfg_wdata,
  input logic [31:0]      cfg_rdata,
  input logic             irq_valid,
  input logic [IRQ_W-1:0] irq_num,
  input logic             chan_en,
  input logic             pat_match,
  input logic             abort_flag_clr,
  input logic             start_pulse,
  input logic             abort_pulse,
  input logic             chan_en_clr,
  input logic             abort_flag
);
  assert_abort_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> !start_pulse);

  assert_start_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_pulse) |-> $past(chan_en));

  assert_clr_is_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en_clr |-> abort_pulse);

  assert_flag_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> abort_flag);

  assert_flag_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(abort_flag_clr) && !abort_pulse) |-> !abort_flag);

  assert_cmd_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:6] == 2'b00);
endmodule

bind dma_evt_trigger dma_evt_trigger_chk #(.IRQ_W(IRQ_W)) u_chk (.*);

// File: tb/tb_dma_evt_trigger.sv
module tb_dma_evt_trigger;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq_valid = 1'b0;
  logic [7:0]  irq_num = '0;
  logic        chan_en = 1'b1;
  logic        pat_match = 1'b0;
  logic        abort_flag_clr = 1'b0;
  logic        start_pulse, abort_pulse, chan_en_clr, abort_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] exp;   // {start, abort, en_clr, flag}
    string      tag;
  } item_t;
  item_t sb[$];

  // bench mirror of the programmed control word
  logic [7:0] m_start = 8'hFF, m_abort = 8'hFF;
  logic       m_pen = 0, m_sen = 0, m_aen = 0, m_flag = 0;

  always #(PERIOD/2) clk = ~clk;

  dma_evt_trigger dut (.*);

  function automatic logic [31:0] word_of();
    return {8'h00, m_abort, m_start, 2'b00, m_pen, m_sen, m_aen, 3'b000};
  endfunction

  task automatic step(input logic we, input logic [31:0] wd, input logic iv,
                      input logic [7:0] num, input logic ce, input logic pm,
                      input logic fc, input string tag);
    logic st, ab, cl;
    item_t it;
    @(negedge clk);
    cfg_we = we; cfg_wdata = wd; irq_valid = iv; irq_num = num;
    chan_en = ce; pat_match = pm; abort_flag_clr = fc;
    cl = m_pen & pm;
    ab = (iv & m_aen & (num == m_abort)) | (we & wd[6]) | cl;
    st = ((iv & m_sen & (num == m_start)) | (we & wd[7])) & ce & ~ab;
    m_flag = ab | (m_flag & ~fc);
    it.exp = {st, ab, cl, m_flag};
    it.tag = tag;
    sb.push_back(it);
    if (we) begin
      m_abort = wd[23:16]; m_start = wd[15:8];
      m_pen = wd[5]; m_sen = wd[4]; m_aen = wd[3];
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic chk_rd(input string tag);
    #1;
    checks++;
    if (cfg_rdata !== word_of()) begin
      errors++;
      $display("FAIL %s rdata actual %h expected %h", tag, cfg_rdata, word_of());
    end
  endtask

  // monitor: compare outputs after each edge with the oldest expectation
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if ({start_pulse, abort_pulse, chan_en_clr, abort_flag} !== it.exp) begin
        errors++;
        $display("FAIL %s {start,abort,clr,flag} actual %b expected %b", it.tag,
                 {start_pulse, abort_pulse, chan_en_clr, abort_flag}, it.exp);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (cfg_rdata !== 32'h00FFFF00 || {start_pulse, abort_pulse, chan_en_clr, abort_flag} !== 4'b0) begin
      errors++;
      $display("FAIL R1 reset actual %h/%b expected 00ffff00/0000", cfg_rdata,
               {start_pulse, abort_pulse, chan_en_clr, abort_flag});
    end
    rst_n = 1'b1;
    idle("R1");
    chk_rd("R1");

    // R2 program fields
    step(1'b1, 32'hAB050A18, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R2");
    idle("R2");
    chk_rd("R2");

    // R3 start matching and non-matching
    step(1'b0, '0, 1'b1, 8'h0A, 1'b1, 1'b0, 1'b0, "R3");
    step(1'b0, '0, 1'b1, 8'h0B, 1'b1, 1'b0, 1'b0, "R3");
    step(1'b0, '0, 1'b0, 8'h0A, 1'b1, 1'b0, 1'b0, "R3");
    // R4 abort interrupt sets flag
    step(1'b0, '0, 1'b1, 8'h05, 1'b1, 1'b0, 1'b0, "R4");
    idle("R10");
    step(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R10");
    idle("R10");

    // R9 start blocked by channel disabled
    step(1'b0, '0, 1'b1, 8'h0A, 1'b0, 1'b0, 1'b0, "R9");
    step(1'b1, 32'h00050A98, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R9");

    // R5 software force
    step(1'b1, 32'h00050A98, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R5");
    idle("R5");
    chk_rd("R2");
    // R6 software abort, flag set by it, not clr (R11)
    step(1'b1, 32'h00050A58, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R6");
    step(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R10");

    // R7 pattern disabled then enabled
    step(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R7");
    step(1'b1, 32'h00050A38, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R7");
    step(1'b0, '0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R7");
    // R8 start interrupt with pattern abort
    step(1'b0, '0, 1'b1, 8'h0A, 1'b1, 1'b1, 1'b1, "R8");
    // R8 force and abort written together
    step(1'b1, 32'h00050AF8, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R8");
    // R11 interrupt abort raises no enable clear
    step(1'b0, '0, 1'b1, 8'h05, 1'b1, 1'b0, 1'b1, "R11");

    // enables clear: interrupts ignored
    step(1'b1, 32'h00050A00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R3");
    step(1'b0, '0, 1'b1, 8'h0A, 1'b1, 1'b0, 1'b0, "R3");
    step(1'b0, '0, 1'b1, 8'h05, 1'b1, 1'b0, 1'b0, "R4");

    // R8 equal fields
    step(1'b1, 32'h00070718, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R8");
    step(1'b0, '0, 1'b1, 8'h07, 1'b1, 1'b0, 1'b0, "R8");
    // R10 set beats clear
    step(1'b0, '0, 1'b1, 8'h07, 1'b1, 1'b0, 1'b1, "R10");
    idle("R10");
    idle("R10");
    chk_rd("R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule